// File: doc/BRIEF.md
# Indexed Control Register File for a Network Controller

This block is the byte-wide configuration and interrupt register file of an Ethernet controller. A host reaches it through two ports selected by one address line: the index port (address line low, the base address) holds the number of the register to be accessed, and the data port (address line high, base plus 4) transfers a byte to or from that register. A host therefore writes the index first and then reads or writes data; the index stays put, so repeated data accesses hit the same register.

The file holds the network control register (loopback select and a self-clearing soft reset), the receive control register, a station address, a multicast hash table, fixed vendor and product identifiers, and an interrupt status/mask pair. Receive, transmit and overflow logic pulse event inputs that set sticky status bits; the host clears them by writing ones. A single interrupt line is raised whenever any status bit is set while its mask bit is enabled. The configuration fields are driven out as plain signals for the datapath around the block.

Top module: `nic_regbank`

## Requirements
- R1: With `host_addr`=0 a write loads the 8-bit register index and a read returns it; with `host_addr`=1 a write stores `host_wdata` into the indexed register and a read returns it combinationally. The index is unchanged by data-port accesses.
- R2: The interrupt status register at index 0xFE holds sticky event bits: bit 0 receive done, bit 1 transmit done, bit 2 receive overflow, bit 3 overflow-counter overflow, each set on the edge where `ev_set[i]` is high. Writing a one to a bit clears it; writing a zero leaves it.
- R3: Bits 7:6 of the status register read the bus width parameter `BUS_MODE` (00 16-bit, 01 32-bit, 10 8-bit); host writes never change them; bits 5:4 read zero.
- R4: The interrupt mask register at index 0xFF stores bits 3:0 (per-event enables) and bit 7 (drives `ptr_wrap_en`); bits 6:4 read zero.
- R5: `irq` is high exactly when some status bit in 3:0 and its mask bit are both set: high in the cycle after an enabled event edge, low after the clearing write.
- R6: If an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R7: The network control register at index 0x00 drives `loop_mode` from bits 2:1 (00 normal, 01 MAC loopback, 10 PHY loopback). Writing bit 0 as one makes it read as one for one cycle; on the next edge every register (control, receive control, station address, multicast table, status, mask) returns to zero and bit 0 reads zero. The index register is not affected.
- R8: The receive control register at index 0x05 drives `rx_enable` (bit 0), `rx_promisc` (bit 1), `rx_all_mcast` (bit 3), `rx_drop_crc` (bit 4) and `rx_drop_long` (bit 5); bits 2, 6 and 7 read zero.
- R9: Index 0x28 reads 0x46, 0x29 reads 0x0A, 0x2A reads 0x00 and 0x2B reads 0x09; writes there have no effect.
- R10: Station address byte k sits at index 0x10+k (k=0..5) and drives `phys_addr[8k+7:8k]`; multicast table byte k sits at index 0x16+k (k=0..7) and drives `mcast_table[8k+7:8k]`.
- R11: Indices outside the listed registers read zero, and writes to them change no output and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 1 | 0 selects the index port, 1 the data port |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Index (port 0) or indexed register (port 1) |
| ev_set | input | NUM_EVT | Event pulses setting status bits |
| irq | output | 1 | Interrupt request |
| loop_mode | output | 2 | Loopback select |
| rx_enable | output | 1 | Receiver enable |
| rx_promisc | output | 1 | Accept all unicast addresses |
| rx_all_mcast | output | 1 | Accept all multicast frames |
| rx_drop_crc | output | 1 | Drop frames with CRC errors |
| rx_drop_long | output | 1 | Drop over-length frames |
| ptr_wrap_en | output | 1 | Buffer pointer wrap-around enable |
| phys_addr | output | 8*PAR_BYTES | Station address |
| mcast_table | output | 8*MAR_BYTES | Multicast hash table |

## Verification
A wrong index or a decode slip shows on the very next data-port read, or as a byte landing in the wrong lane of `phys_addr`/`mcast_table` one cycle after the write. A status bit that fails to stick, clears on a zero, or loses a same-cycle race against a clear shows on `irq` one cycle after the event edge and on the status readback. A soft reset that does not self-clear, clears early, or misses a register shows one cycle after the control write, when every configuration output must already be back at zero.

// File: rtl/nic_regbank_pkg.sv
package nic_regbank_pkg;
   localparam logic [7:0] IDX_NETCTL = 8'h00;
   localparam logic [7:0] IDX_RXCTL  = 8'h05;
   localparam logic [7:0] IDX_PHYS   = 8'h10;
   localparam logic [7:0] IDX_MCAST  = 8'h16;
   localparam logic [7:0] IDX_VID    = 8'h28;
   localparam logic [7:0] IDX_PID    = 8'h2A;
   localparam logic [7:0] IDX_ISTAT  = 8'hFE;
   localparam logic [7:0] IDX_IMASK  = 8'hFF;

   // writable bit masks
   localparam logic [7:0] NETCTL_WMASK = 8'h07;
   localparam logic [7:0] RXCTL_WMASK  = 8'h3B;

   typedef enum logic [1:0] {
      LOOP_NONE = 2'b00,
      LOOP_MAC  = 2'b01,
      LOOP_PHY  = 2'b10
   } loop_e;

   typedef struct packed {
      logic drop_long;
      logic drop_crc;
      logic all_mcast;
      logic promisc;
      logic rx_en;
   } rxcfg_t;
endpackage

// File: rtl/nic_idx_port.sv
module nic_idx_port #(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_addr,
   input  logic             host_wr,
   input  logic [IDX_W-1:0] host_wdata,
   output logic [IDX_W-1:0] idx,
   output logic             data_we
);
   logic [IDX_W-1:0] idx_q;
   logic             idx_we;

   assign idx_we  = host_wr && !host_addr;
   assign data_we = host_wr &&  host_addr;
   assign idx     = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx_q <= '0;
      else if (idx_we) idx_q <= host_wdata;
   end

   // R1: index holds across anything but an index-port write
   a_r1_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_wr && !host_addr) |=> $stable(idx_q));
endmodule

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs
   import nic_regbank_pkg::*;
#(
   parameter int PAR_BYTES = 6,
   parameter int MAR_BYTES = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [7:0]             idx,
   input  logic                   data_we,
   input  logic [7:0]             wdata,
   output logic                   srst,
   output loop_e                  loop_mode,
   output rxcfg_t                 rxcfg,
   output logic [8*PAR_BYTES-1:0] phys_addr,
   output logic [8*MAR_BYTES-1:0] mcast_table,
   output logic                   rd_hit,
   output logic [7:0]             rd_data
);
   logic [7:0] ncr_q, rcr_q;
   logic [7:0] par_q [PAR_BYTES];
   logic [7:0] mar_q [MAR_BYTES];

   assign srst = ncr_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ncr_q <= '0;
         rcr_q <= '0;
      end else if (srst) begin
         ncr_q <= '0;
         rcr_q <= '0;
      end else if (data_we) begin
         if (idx == IDX_NETCTL) ncr_q <= wdata & NETCTL_WMASK;
         if (idx == IDX_RXCTL)  rcr_q <= wdata & RXCTL_WMASK;
      end
   end

   for (genvar k = 0; k < PAR_BYTES; k++) begin : g_par
      localparam logic [7:0] MY_IDX = 8'(int'(IDX_PHYS) + k);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         par_q[k] <= '0;
         else if (srst)                      par_q[k] <= '0;
         else if (data_we && idx == MY_IDX)  par_q[k] <= wdata;
      end
      assign phys_addr[8*k +: 8] = par_q[k];
   end

   for (genvar k = 0; k < MAR_BYTES; k++) begin : g_mar
      localparam logic [7:0] MY_IDX = 8'(int'(IDX_MCAST) + k);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         mar_q[k] <= '0;
         else if (srst)                      mar_q[k] <= '0;
         else if (data_we && idx == MY_IDX)  mar_q[k] <= wdata;
      end
      assign mcast_table[8*k +: 8] = mar_q[k];
   end

   assign loop_mode = loop_e'(ncr_q[2:1]);
   assign rxcfg     = '{drop_long: rcr_q[5], drop_crc: rcr_q[4],
                        all_mcast: rcr_q[3], promisc: rcr_q[1], rx_en: rcr_q[0]};

   always_comb begin
      rd_hit  = 1'b0;
      rd_data = '0;
      if (idx == IDX_NETCTL) begin rd_hit = 1'b1; rd_data = ncr_q; end
      if (idx == IDX_RXCTL)  begin rd_hit = 1'b1; rd_data = rcr_q; end
      for (int k = 0; k < PAR_BYTES; k++)
         if (idx == 8'(int'(IDX_PHYS) + k))  begin rd_hit = 1'b1; rd_data = par_q[k]; end
      for (int k = 0; k < MAR_BYTES; k++)
         if (idx == 8'(int'(IDX_MCAST) + k)) begin rd_hit = 1'b1; rd_data = mar_q[k]; end
   end

   // R7: the reset bit lives one cycle and wipes control state
   a_r7_srst_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
      ncr_q[0] |=> (ncr_q == '0 && rcr_q == '0));
   a_r7_srst_wipes_addr: assert property (@(posedge clk) disable iff (!rst_n)
      ncr_q[0] |=> (phys_addr == '0 && mcast_table == '0));
endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
   import nic_regbank_pkg::*;
#(
   parameter int         NUM_EVT  = 4,
   parameter logic [1:0] BUS_MODE = 2'b00
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               srst,
   input  logic [7:0]         idx,
   input  logic               data_we,
   input  logic [7:0]         wdata,
   input  logic [NUM_EVT-1:0] ev_set,
   output logic               irq,
   output logic               ptr_wrap_en,
   output logic               rd_hit,
   output logic [7:0]         rd_data
);
   localparam logic [7:0] EVT_BITS   = 8'((1 << NUM_EVT) - 1);
   localparam logic [7:0] MASK_WBITS = EVT_BITS | 8'h80;

   logic [7:0] sts_q, msk_q, ev8, clr8, sts_nxt;
   logic       sts_we, msk_we;

   assign sts_we  = data_we && idx == IDX_ISTAT;
   assign msk_we  = data_we && idx == IDX_IMASK;
   assign ev8     = 8'(ev_set);
   assign clr8    = sts_we ? (wdata & EVT_BITS) : 8'h00;
   // set beats clear on a collision
   assign sts_nxt = (sts_q & ~clr8) | ev8;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q <= '0;
         msk_q <= '0;
      end else if (srst) begin
         sts_q <= '0;
         msk_q <= '0;
      end else begin
         sts_q <= sts_nxt;
         if (msk_we) msk_q <= wdata & MASK_WBITS;
      end
   end

   assign irq         = |(sts_q & msk_q & EVT_BITS);
   assign ptr_wrap_en = msk_q[7];

   always_comb begin
      rd_hit  = 1'b0;
      rd_data = '0;
      if (idx == IDX_ISTAT) begin
         rd_hit       = 1'b1;
         rd_data      = sts_q;
         rd_data[7:6] = BUS_MODE;
      end
      if (idx == IDX_IMASK) begin
         rd_hit  = 1'b1;
         rd_data = msk_q;
      end
   end

   for (genvar i = 0; i < NUM_EVT; i++) begin : g_chk
      // R6: a pending event always lands
      a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (ev_set[i] && !srst) |=> sts_q[i]);
      // R2: a one written without a racing event clears
      a_r2_w1c: assert property (@(posedge clk) disable iff (!rst_n)
         (sts_we && wdata[i] && !ev_set[i]) |=> !sts_q[i]);
   end

   // R5: an enabled event raises the line next cycle
   a_r5_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(ev8 & msk_q & EVT_BITS)) && !srst && !msk_we) |=> irq);
endmodule

// File: rtl/nic_regbank.sv
module nic_regbank
   import nic_regbank_pkg::*;
#(
   parameter int          PAR_BYTES  = 6,
   parameter int          MAR_BYTES  = 8,
   parameter int          NUM_EVT    = 4,
   parameter logic [1:0]  BUS_MODE   = 2'b00,
   parameter logic [15:0] VENDOR_ID  = 16'h0A46,
   parameter logic [15:0] PRODUCT_ID = 16'h0900
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   host_addr,
   input  logic                   host_wr,
   input  logic [7:0]             host_wdata,
   output logic [7:0]             host_rdata,
   input  logic [NUM_EVT-1:0]     ev_set,
   output logic                   irq,
   output logic [1:0]             loop_mode,
   output logic                   rx_enable,
   output logic                   rx_promisc,
   output logic                   rx_all_mcast,
   output logic                   rx_drop_crc,
   output logic                   rx_drop_long,
   output logic                   ptr_wrap_en,
   output logic [8*PAR_BYTES-1:0] phys_addr,
   output logic [8*MAR_BYTES-1:0] mcast_table
);
   if (PAR_BYTES < 1 || int'(IDX_PHYS) + PAR_BYTES > int'(IDX_MCAST)) begin : g_bad_par
      $error("PAR_BYTES overlaps the multicast table");
   end
   if (MAR_BYTES < 1 || int'(IDX_MCAST) + MAR_BYTES > int'(IDX_VID)) begin : g_bad_mar
      $error("MAR_BYTES overlaps the identifier registers");
   end
   if (NUM_EVT < 1 || NUM_EVT > 6) begin : g_bad_evt
      $error("NUM_EVT must leave status bits 7:6 for the bus width");
   end
   if (BUS_MODE == 2'b11) begin : g_bad_bus
      $error("BUS_MODE 11 is not a defined width");
   end

   logic [7:0] idx, cfg_rd, irq_rd, id_rd;
   logic       data_we, srst, cfg_hit, irq_hit;
   loop_e      loop_sel;
   rxcfg_t     rxcfg;

   nic_idx_port #(.IDX_W(8)) u_idx (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_wdata(host_wdata), .idx(idx), .data_we(data_we));

   nic_cfg_regs #(.PAR_BYTES(PAR_BYTES), .MAR_BYTES(MAR_BYTES)) u_cfg (
      .clk(clk), .rst_n(rst_n), .idx(idx), .data_we(data_we), .wdata(host_wdata),
      .srst(srst), .loop_mode(loop_sel), .rxcfg(rxcfg), .phys_addr(phys_addr),
      .mcast_table(mcast_table), .rd_hit(cfg_hit), .rd_data(cfg_rd));

   nic_irq_ctrl #(.NUM_EVT(NUM_EVT), .BUS_MODE(BUS_MODE)) u_irq (
      .clk(clk), .rst_n(rst_n), .srst(srst), .idx(idx), .data_we(data_we),
      .wdata(host_wdata), .ev_set(ev_set), .irq(irq), .ptr_wrap_en(ptr_wrap_en),
      .rd_hit(irq_hit), .rd_data(irq_rd));

   always_comb begin
      case (idx)
         IDX_VID:        id_rd = VENDOR_ID[7:0];
         IDX_VID + 8'd1: id_rd = VENDOR_ID[15:8];
         IDX_PID:        id_rd = PRODUCT_ID[7:0];
         IDX_PID + 8'd1: id_rd = PRODUCT_ID[15:8];
         default:        id_rd = '0;
      endcase
   end

   always_comb begin
      if (!host_addr)   host_rdata = idx;
      else if (cfg_hit) host_rdata = cfg_rd;
      else if (irq_hit) host_rdata = irq_rd;
      else              host_rdata = id_rd;
   end

   assign loop_mode    = loop_sel;
   assign rx_enable    = rxcfg.rx_en;
   assign rx_promisc   = rxcfg.promisc;
   assign rx_all_mcast = rxcfg.all_mcast;
   assign rx_drop_crc  = rxcfg.drop_crc;
   assign rx_drop_long = rxcfg.drop_long;
endmodule

// File: tb/nic_regbank_tb.sv
module nic_regbank_tb;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        host_addr = 0, host_wr = 0;
   logic [7:0]  host_wdata = 0;
   logic [7:0]  host_rdata;
   logic [3:0]  ev_set = 0;
   logic        irq, rx_enable, rx_promisc, rx_all_mcast, rx_drop_crc, rx_drop_long, ptr_wrap_en;
   logic [1:0]  loop_mode;
   logic [47:0] phys_addr;
   logic [63:0] mcast_table;
   int          n_chk = 0, n_err = 0;
   bit          finished = 0;

   always #10 clk = ~clk;

   nic_regbank #(.BUS_MODE(2'b10)) u_dut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .ev_set(ev_set), .irq(irq),
      .loop_mode(loop_mode), .rx_enable(rx_enable), .rx_promisc(rx_promisc),
      .rx_all_mcast(rx_all_mcast), .rx_drop_crc(rx_drop_crc), .rx_drop_long(rx_drop_long),
      .ptr_wrap_en(ptr_wrap_en), .phys_addr(phys_addr), .mcast_table(mcast_table));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wr = 1; host_wdata = d;
      @(negedge clk);
      host_wr = 0;
   endtask

   task automatic rd(input logic [7:0] ix, output logic [7:0] v);
      wr(0, ix);
      host_addr = 1; #1;
      v = host_rdata;
   endtask

   task automatic pulse(input logic [3:0] e);
      @(negedge clk); ev_set = e;
      @(negedge clk); ev_set = 0;
      #1;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk("R7 reset loop", 64'(loop_mode), 0);
      chk("R5 reset irq", 64'(irq), 0);
      rd(8'hFE, v); chk("R3 reset status", 64'(v), 64'h80);
   endtask

   task automatic t_index_port();
      logic [7:0] v;
      wr(0, 8'h5A); host_addr = 0; #1;
      chk("R1 index readback", 64'(host_rdata), 64'h5A);
      wr(0, 8'h10); wr(1, 8'h11); wr(1, 8'h22);
      #1; chk("R1 index held", 64'(phys_addr[15:0]), 64'h0022);
      host_addr = 0; #1; chk("R1 index after data", 64'(host_rdata), 64'h10);
      rd(8'h10, v); chk("R1 data read", 64'(v), 64'h22);
   endtask

   task automatic t_ids();
      logic [7:0] v;
      wr(0, 8'h28); wr(1, 8'hFF);
      rd(8'h28, v); chk("R9 vid lo", 64'(v), 64'h46);
      rd(8'h29, v); chk("R9 vid hi", 64'(v), 64'h0A);
      rd(8'h2A, v); chk("R9 pid lo", 64'(v), 64'h00);
      rd(8'h2B, v); chk("R9 pid hi", 64'(v), 64'h09);
   endtask

   task automatic t_addr_tables();
      logic [47:0] pe = '0;
      logic [63:0] me = '0;
      for (int k = 0; k < 6; k++) begin
         wr(0, 8'(8'h10 + k)); wr(1, 8'(8'hA0 + k)); pe[8*k +: 8] = 8'(8'hA0 + k);
      end
      for (int k = 0; k < 8; k++) begin
         wr(0, 8'(8'h16 + k)); wr(1, 8'(8'hC1 + 3*k)); me[8*k +: 8] = 8'(8'hC1 + 3*k);
      end
      #1;
      chk("R10 station address", 64'(phys_addr), 64'(pe));
      chk("R10 multicast table", mcast_table, me);
   endtask

   task automatic t_rxctl();
      logic [7:0] v;
      wr(0, 8'h05); wr(1, 8'hFF);
      rd(8'h05, v); chk("R8 rx ctrl read", 64'(v), 64'h3B);
      chk("R8 rx outputs", 64'({rx_drop_long, rx_drop_crc, rx_all_mcast, rx_promisc, rx_enable}), 64'h1F);
      wr(0, 8'h05); wr(1, 8'h0A); #1;
      chk("R8 rx outputs pattern", 64'({rx_drop_long, rx_drop_crc, rx_all_mcast, rx_promisc, rx_enable}), 64'h06);
   endtask

   task automatic t_mask_irq();
      logic [7:0] v;
      wr(0, 8'hFF); wr(1, 8'hFF);
      rd(8'hFF, v); chk("R4 mask read", 64'(v), 64'h8F);
      chk("R4 wrap out", 64'(ptr_wrap_en), 1);
      wr(0, 8'hFF); wr(1, 8'h02);
      pulse(4'b0001);
      chk("R5 masked event no irq", 64'(irq), 0);
      rd(8'hFE, v); chk("R2 rx done set", 64'(v), 64'h81);
      pulse(4'b0010);
      chk("R5 enabled event irq", 64'(irq), 1);
      wr(0, 8'hFE); wr(1, 8'h00); #1;
      chk("R2 zero write keeps", 64'(irq), 1);
      wr(1, 8'h02); #1;
      chk("R5 irq drops after clear", 64'(irq), 0);
      rd(8'hFE, v); chk("R2 only bit1 cleared", 64'(v), 64'h81);
      pulse(4'b1100);
      rd(8'hFE, v); chk("R2 overflow bits", 64'(v), 64'h8D);
      wr(0, 8'hFE); wr(1, 8'h0F);
      rd(8'hFE, v); chk("R2 clear all", 64'(v), 64'h80);
   endtask

   task automatic t_set_wins();
      logic [7:0] v;
      wr(0, 8'hFE);
      @(negedge clk);
      host_addr = 1; host_wr = 1; host_wdata = 8'h04; ev_set = 4'b0100;
      @(negedge clk);
      host_wr = 0; ev_set = 0;
      rd(8'hFE, v); chk("R6 set wins", 64'(v), 64'h84);
   endtask

   task automatic t_busw();
      logic [7:0] v;
      wr(0, 8'hFE); wr(1, 8'hF0);
      rd(8'hFE, v); chk("R3 bus width kept", 64'(v), 64'h84);
   endtask

   task automatic t_unmapped();
      logic [7:0] v;
      wr(0, 8'h40); wr(1, 8'hFF);
      rd(8'h40, v); chk("R11 unmapped read", 64'(v), 0);
      chk("R11 outputs untouched", 64'({loop_mode, rx_enable, ptr_wrap_en}), 64'h0);
      rd(8'h1E, v); chk("R11 past table", 64'(v), 0);
   endtask

   task automatic t_soft_reset();
      logic [7:0] v;
      wr(0, 8'hFF); wr(1, 8'h84);
      chk("R7 pre irq", 64'(irq), 1);
      wr(0, 8'h00); wr(1, 8'h03);
      host_addr = 1; #1;
      chk("R7 reset bit visible", 64'(host_rdata), 64'h03);
      chk("R7 mac loopback", 64'(loop_mode), 1);
      @(negedge clk); #1;
      chk("R7 reset bit cleared", 64'(host_rdata), 0);
      chk("R7 cfg cleared", 64'({loop_mode, rx_enable, rx_promisc, ptr_wrap_en, irq}), 0);
      chk("R7 station cleared", 64'(phys_addr), 0);
      chk("R7 mcast cleared", mcast_table, 0);
      wr(1, 8'h04); #1;
      chk("R7 index kept, phy loopback", 64'(loop_mode), 2);
      rd(8'hFE, v); chk("R7 status cleared", 64'(v), 64'h80);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_index_port();
      t_ids();
      t_addr_tables();
      t_rxctl();
      t_mask_irq();
      t_set_wins();
      t_busw();
      t_unmapped();
      t_soft_reset();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule